// File: doc/BRIEF.md
# Multi-port ATM cell transmit ingress with parity logging

This block sits on the transmit side of a multi-port cell interface. An ATM layer device drives one shared byte-wide bus, a start-of-cell flag and an odd-parity bit. It also drives one active-low enable per port, sampled on a free-running clock. When exactly one enable is low, that enable names the port that owns the byte. The block counts the bytes of each cell. It writes them into the chosen port's cell FIFO and makes a cell visible on that port's read side only once all of its bytes have arrived. Each port reports through its own cell-available output whether its FIFO can take a further whole cell.

Every byte that is transferred is checked for odd parity. A parity error does not touch the data path. It can only set a sticky per-port bit in an interrupt status register, and only when the matching bit of a master control register allows it. Software clears a status bit by writing a one to it. Cell length, FIFO depth in cells, port count and bus width are parameters.

Top module: `utx_ingress`

## Requirements
- R1: A byte is transferred only on a clock edge where exactly one bit of `tx_en_n` is low, and that bit's index is the destination port. On an edge with no enable low, or with more than one low, the byte is neither written nor parity-checked.
- R2: A cell is `CELL_BYTES` transferred bytes and begins with a byte that has `tx_soc` high. A non-start byte is discarded when no cell is open or when it selects a port other than the open cell's port.
- R3: A cell becomes readable only after its last byte has been written. `rd_avail[p]` is high while port p holds committed bytes. `rd_data` shows the oldest byte, and `rd_pop[p]` advances to the next byte in write order.
- R4: `tx_clav[p]` is high exactly when port p's free space is at least `CELL_BYTES`. The bytes already written for an open cell count as used.
- R5: A start byte aimed at a port with no room for a whole cell drops that entire cell.
- R6: A start byte that arrives while a cell is open discards the partial cell and opens a new one. When the new cell is on the same port, the partial bytes are freed first.
- R7: A parity error is a transferred byte whose eight data bits and `tx_par` together hold an even number of ones. It sets bit p of `par_sts` only if bit p of `par_en` is one.
- R8: A parity error has no effect on the data path: the byte is still written and its cell is delivered unchanged.
- R9: `par_sts` bits are sticky. Writing with `sts_clr_we` clears each bit that is one in `sts_clr_data`, but a parity error in the same cycle leaves its bit set.
- R10: `ctl_we` loads `ctl_wdata` into the master control register, which reads back on `par_en`.
- R11: After reset all FIFOs are empty, every `tx_clav` bit is high, and `par_en` and `par_sts` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_n | input | NPORT | Per-port active-low transmit enable |
| tx_data | input | DW | Shared transmit data byte |
| tx_soc | input | 1 | High with the first byte of a cell |
| tx_par | input | 1 | Odd parity bit for `tx_data` |
| tx_clav | output | NPORT | Per-port room-for-a-cell flag |
| rd_pop | input | NPORT | Per-port read advance |
| rd_avail | output | NPORT | Per-port committed data present |
| rd_data | output | NPORT*DW | Per-port head byte, port p at bits p*DW upward |
| ctl_we | input | 1 | Master control register write strobe |
| ctl_wdata | input | NPORT | Master control write value |
| par_en | output | NPORT | Master control register contents |
| sts_clr_we | input | 1 | Status write-one-to-clear strobe |
| sts_clr_data | input | NPORT | Bits of status to clear |
| par_sts | output | NPORT | Sticky parity error status |

## Verification
The bench builds the block with four ports, six-byte cells and two cells of storage per port. With these values a FIFO fills after twelve bytes. The bench can therefore exercise a full port dropping a cell, a pending partial cell pulling `tx_clav` low, and restarts on the same port and on another port within a short run. A scoreboard queue per port holds the bytes that should reach the read side, and a drain process compares every popped byte against it.

// File: rtl/utx_pkg.sv
package utx_pkg;
   typedef enum logic {
      CAP_IDLE = 1'b0,
      CAP_OPEN = 1'b1
   } cap_st_e;
endpackage

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo #(
   parameter int DW         = 8,
   parameter int CELL_BYTES = 53,
   parameter int CELL_SLOTS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          abort,
   input  logic          commit,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          avail,
   output logic          clav,
   output logic          room_commit,
   output logic          busy
);
   localparam int DEPTH = CELL_BYTES * CELL_SLOTS;
   localparam int AW    = $clog2(DEPTH);
   localparam int CW    = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
   localparam logic [CW-1:0] CELL_C  = CW'(CELL_BYTES);
   localparam logic [CW-1:0] ONE_C   = CW'(1);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] rptr, cptr, tptr, addr;
   logic [AW-1:0] rptr_n, cptr_n, tptr_n;
   logic [CW-1:0] used, pend, used_n, pend_n, pend_b, pend_w;
   logic          do_pop;

   function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
      return (p == LAST_A) ? '0 : p + AW'(1);
   endfunction

   always_comb begin
      addr   = abort ? cptr : tptr;
      pend_b = abort ? '0 : pend;
      pend_w = wr ? pend_b + ONE_C : pend_b;
      do_pop = pop && (used != '0);
      tptr_n = wr ? inc(addr) : addr;
      cptr_n = commit ? inc(addr) : cptr;
      pend_n = commit ? '0 : pend_w;
      used_n = used + (commit ? pend_w : '0) - (do_pop ? ONE_C : '0);
      rptr_n = do_pop ? inc(rptr) : rptr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr <= '0;
         cptr <= '0;
         tptr <= '0;
         used <= '0;
         pend <= '0;
      end else begin
         rptr <= rptr_n;
         cptr <= cptr_n;
         tptr <= tptr_n;
         used <= used_n;
         pend <= pend_n;
      end
   end

   always_ff @(posedge clk) begin
      if (wr) mem[addr] <= din;
   end

   assign dout        = mem[rptr];
   assign avail       = (used != '0);
   assign clav        = (DEPTH_C - used - pend) >= CELL_C;
   assign room_commit = (DEPTH_C - used) >= CELL_C;
   assign busy        = (pend != '0);

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (used + pend) <= DEPTH_C);

   // R2
   cell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (wr && !abort && (pend == CELL_C - ONE_C)));

   // R3
   avail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(avail) |-> $past(pop));
endmodule

// File: rtl/utx_capture.sv
module utx_capture
   import utx_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int DW         = 8,
   parameter int CELL_BYTES = 53
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] en_n,
   input  logic [DW-1:0]    data,
   input  logic             soc,
   input  logic             par,
   input  logic [NPORT-1:0] clav,
   input  logic [NPORT-1:0] room_commit,
   output logic [NPORT-1:0] wr,
   output logic [NPORT-1:0] abort,
   output logic [NPORT-1:0] commit,
   output logic [NPORT-1:0] perr
);
   localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1;
   localparam int CNTW = $clog2(CELL_BYTES);
   localparam logic [CNTW-1:0] LASTB = CNTW'(CELL_BYTES - 1);

   cap_st_e         st, st_n;
   logic [PW-1:0]   cur, cur_n, sel_idx;
   logic [CNTW-1:0] cnt, cnt_n;
   logic [NPORT-1:0] sel;
   logic            xfer, same, room;

   assign sel  = ~en_n;
   assign xfer = $onehot(sel);

   always_comb begin
      sel_idx = '0;
      for (int i = 0; i < NPORT; i++) begin
         if (sel[i]) sel_idx = PW'(i);
      end
   end

   assign perr = (xfer && !(^{data, par})) ? sel : '0;

   always_comb begin
      wr     = '0;
      abort  = '0;
      commit = '0;
      st_n   = st;
      cur_n  = cur;
      cnt_n  = cnt;
      same   = 1'b0;
      room   = 1'b0;
      if (xfer && soc) begin
         if (st == CAP_OPEN) abort[cur] = 1'b1;
         same = (st == CAP_OPEN) && (cur == sel_idx);
         room = same ? room_commit[sel_idx] : clav[sel_idx];
         if (room) begin
            wr[sel_idx] = 1'b1;
            st_n        = CAP_OPEN;
            cur_n       = sel_idx;
            cnt_n       = CNTW'(1);
         end else begin
            st_n = CAP_IDLE;
         end
      end else if (xfer && (st == CAP_OPEN) && (sel_idx == cur)) begin
         wr[cur] = 1'b1;
         if (cnt == LASTB) begin
            commit[cur] = 1'b1;
            st_n        = CAP_IDLE;
         end else begin
            cnt_n = cnt + CNTW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= CAP_IDLE;
         cur <= '0;
         cnt <= '0;
      end else begin
         st  <= st_n;
         cur <= cur_n;
         cnt <= cnt_n;
      end
   end
endmodule

// File: rtl/utx_par_regs.sv
module utx_par_regs #(
   parameter int NPORT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] perr,
   input  logic             ctl_we,
   input  logic [NPORT-1:0] ctl_wdata,
   input  logic             clr_we,
   input  logic [NPORT-1:0] clr_data,
   output logic [NPORT-1:0] en,
   output logic [NPORT-1:0] sts
);
   logic [NPORT-1:0] clr_mask;

   assign clr_mask = clr_we ? clr_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en  <= '0;
         sts <= '0;
      end else begin
         if (ctl_we) en <= ctl_wdata;
         sts <= (sts & ~clr_mask) | (perr & en);
      end
   end

   // R7
   no_silent_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts & ~$past(sts) & ~$past(en)) == '0);

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sts) & ~sts & ~$past(clr_mask)) == '0);
endmodule

// File: rtl/utx_ingress.sv
module utx_ingress #(
   parameter int NPORT      = 4,
   parameter int DW         = 8,
   parameter int CELL_BYTES = 53,
   parameter int CELL_SLOTS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    tx_en_n,
   input  logic [DW-1:0]       tx_data,
   input  logic                tx_soc,
   input  logic                tx_par,
   output logic [NPORT-1:0]    tx_clav,
   input  logic [NPORT-1:0]    rd_pop,
   output logic [NPORT-1:0]    rd_avail,
   output logic [NPORT*DW-1:0] rd_data,
   input  logic                ctl_we,
   input  logic [NPORT-1:0]    ctl_wdata,
   output logic [NPORT-1:0]    par_en,
   input  logic                sts_clr_we,
   input  logic [NPORT-1:0]    sts_clr_data,
   output logic [NPORT-1:0]    par_sts
);
   if (NPORT < 2) begin : g_bad_nport
      $error("utx_ingress: NPORT must be at least 2");
   end
   if (CELL_BYTES < 2) begin : g_bad_cell
      $error("utx_ingress: CELL_BYTES must be at least 2");
   end
   if (CELL_SLOTS < 1) begin : g_bad_slots
      $error("utx_ingress: CELL_SLOTS must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("utx_ingress: DW must be positive");
   end

   logic [NPORT-1:0] wr, abort, commit, perr, room_commit, busy;

   utx_capture #(
      .NPORT     (NPORT),
      .DW        (DW),
      .CELL_BYTES(CELL_BYTES)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_n       (tx_en_n),
      .data       (tx_data),
      .soc        (tx_soc),
      .par        (tx_par),
      .clav       (tx_clav),
      .room_commit(room_commit),
      .wr         (wr),
      .abort      (abort),
      .commit     (commit),
      .perr       (perr)
   );

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      utx_cell_fifo #(
         .DW        (DW),
         .CELL_BYTES(CELL_BYTES),
         .CELL_SLOTS(CELL_SLOTS)
      ) u_fifo (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr         (wr[g]),
         .abort      (abort[g]),
         .commit     (commit[g]),
         .din        (tx_data),
         .pop        (rd_pop[g]),
         .dout       (rd_data[g*DW +: DW]),
         .avail      (rd_avail[g]),
         .clav       (tx_clav[g]),
         .room_commit(room_commit[g]),
         .busy       (busy[g])
      );
   end

   utx_par_regs #(
      .NPORT(NPORT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .perr     (perr),
      .ctl_we   (ctl_we),
      .ctl_wdata(ctl_wdata),
      .clr_we   (sts_clr_we),
      .clr_data (sts_clr_data),
      .en       (par_en),
      .sts      (par_sts)
   );

   // R6
   one_open_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy));
endmodule

// File: tb/utx_ingress_bench.sv
module utx_ingress_bench;
   localparam int NP = 4;
   localparam int CB = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] tx_en_n = '1;
   logic [7:0]    tx_data = '0;
   logic          tx_soc = 1'b0;
   logic          tx_par = 1'b0;
   logic [NP-1:0] tx_clav;
   logic [NP-1:0] rd_pop = '0;
   logic [NP-1:0] rd_avail;
   logic [NP*8-1:0] rd_data;
   logic          ctl_we = 1'b0;
   logic [NP-1:0] ctl_wdata = '0;
   logic [NP-1:0] par_en;
   logic          sts_clr_we = 1'b0;
   logic [NP-1:0] sts_clr_data = '0;
   logic [NP-1:0] par_sts;

   int  checks = 0;
   int  failures = 0;
   bit  drain_on = 1'b0;
   logic [7:0] exp_q [NP][$];

   always #2ns clk = ~clk;

   utx_ingress #(
      .NPORT(NP), .DW(8), .CELL_BYTES(CB), .CELL_SLOTS(2)
   ) u_utx_ingress (
      .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_data(tx_data),
      .tx_soc(tx_soc), .tx_par(tx_par), .tx_clav(tx_clav), .rd_pop(rd_pop),
      .rd_avail(rd_avail), .rd_data(rd_data), .ctl_we(ctl_we),
      .ctl_wdata(ctl_wdata), .par_en(par_en), .sts_clr_we(sts_clr_we),
      .sts_clr_data(sts_clr_data), .par_sts(par_sts)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops committed bytes and compares with the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         for (int p = 0; p < NP; p++) begin
            rd_pop[p] = 1'b0;
            if (drain_on && rd_avail[p]) begin
               if (exp_q[p].size() == 0) begin
                  chk(1'b0, "R3 unexpected byte", int'(rd_data[p*8 +: 8]), -1);
               end else begin
                  logic [7:0] e;
                  e = exp_q[p].pop_front();
                  chk(rd_data[p*8 +: 8] == e, "R1/R3/R8 byte order", int'(rd_data[p*8 +: 8]), int'(e));
               end
               rd_pop[p] = 1'b1;
            end
         end
      end
   end

   task automatic send(input logic [NP-1:0] en_n, input logic [7:0] d, input logic soc, input bit bad);
      tx_en_n = en_n;
      tx_data = d;
      tx_soc  = soc;
      tx_par  = bad ? (^d) : ~(^d);
      @(negedge clk);
      tx_en_n = '1;
      tx_soc  = 1'b0;
   endtask

   task automatic send_cell(input int port, input logic [7:0] seed, input int bad_idx, input bit push);
      for (int i = 0; i < CB; i++) begin
         logic [7:0] d;
         d = seed + 8'(i);
         if (push) exp_q[port].push_back(d);
         send(~(NP'(1) << port), d, i == 0, i == bad_idx);
      end
   endtask

   task automatic wait_drain(input string tag);
      for (int n = 0; n < 400; n++) begin
         if (exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size() == 0) break;
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size() == 0,
          tag, exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size(), 0);
      chk(rd_avail == '0, tag, int'(rd_avail), 0);
   endtask

   task automatic ctl_write(input logic [NP-1:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic sts_clear(input logic [NP-1:0] v);
      sts_clr_we = 1'b1; sts_clr_data = v;
      @(negedge clk);
      sts_clr_we = 1'b0;
   endtask

   initial begin
      #400us;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(tx_clav == 4'hF, "R11 clav", int'(tx_clav), 15);
      chk(rd_avail == '0, "R11 avail", int'(rd_avail), 0);
      chk(par_sts == '0, "R11 sts", int'(par_sts), 0);
      chk(par_en == '0, "R11 en", int'(par_en), 0);

      // R1 routing to every port
      drain_on = 1'b1;
      for (int p = 0; p < NP; p++) send_cell(p, 8'(8'h10 * (p + 1)), -1, 1'b1);
      wait_drain("R1 all ports delivered");

      // R3 partial cell not readable
      drain_on = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         exp_q[1].push_back(8'h30 + 8'(i));
         send(4'b1101, 8'h30 + 8'(i), i == 0, 1'b0);
      end
      chk(rd_avail[1] == 1'b0, "R3 partial hidden", int'(rd_avail[1]), 0);
      for (int i = 3; i < CB; i++) begin
         exp_q[1].push_back(8'h30 + 8'(i));
         send(4'b1101, 8'h30 + 8'(i), 1'b0, 1'b0);
      end
      chk(rd_avail[1] == 1'b1, "R3 whole cell visible", int'(rd_avail[1]), 1);
      drain_on = 1'b1;
      wait_drain("R3 drained");

      // R1/R2 ignored bytes in the middle of a cell; all parity enables on
      ctl_write(4'hF);
      chk(par_en == 4'hF, "R10 readback all", int'(par_en), 15);
      exp_q[2].push_back(8'h40);
      send(4'b1011, 8'h40, 1'b1, 1'b0);
      send(4'b0011, 8'hEE, 1'b0, 1'b1);
      send(4'b1111, 8'hDD, 1'b0, 1'b1);
      send(4'b1110, 8'hCC, 1'b0, 1'b0);
      for (int i = 1; i < CB; i++) begin
         exp_q[2].push_back(8'h40 + 8'(i));
         send(4'b1011, 8'h40 + 8'(i), 1'b0, 1'b0);
      end
      chk(par_sts == '0, "R1 ignored bytes not checked", int'(par_sts), 0);
      wait_drain("R2 foreign bytes dropped");

      // R7/R8/R10 parity logging
      ctl_write(4'b0100);
      chk(par_en == 4'b0100, "R10 readback", int'(par_en), 4);
      send_cell(1, 8'h50, 2, 1'b1);
      chk(par_sts == '0, "R7 masked port", int'(par_sts), 0);
      send_cell(2, 8'h60, 4, 1'b1);
      chk(par_sts == 4'b0100, "R7 enabled port", int'(par_sts), 4);
      wait_drain("R8 data kept on error");

      // R9 clear, sticky, set wins over clear
      sts_clear(4'b0100);
      chk(par_sts == '0, "R9 w1c", int'(par_sts), 0);
      send(4'b1010, 8'h77, 1'b1, 1'b1);
      chk(par_sts == '0, "R1 two enables low", int'(par_sts), 0);
      send_cell(2, 8'h70, 0, 1'b1);
      send_cell(2, 8'h80, -1, 1'b1);
      chk(par_sts == 4'b0100, "R9 sticky", int'(par_sts), 4);
      sts_clear(4'b0001);
      chk(par_sts == 4'b0100, "R9 clear other bit", int'(par_sts), 4);
      exp_q[2].push_back(8'h90);
      send(4'b1011, 8'h90, 1'b1, 1'b0);
      exp_q[2].push_back(8'h91);
      sts_clr_we = 1'b1; sts_clr_data = 4'b0100;
      send(4'b1011, 8'h91, 1'b0, 1'b1);
      sts_clr_we = 1'b0;
      chk(par_sts == 4'b0100, "R9 set wins", int'(par_sts), 4);
      for (int i = 2; i < CB; i++) begin
         exp_q[2].push_back(8'h90 + 8'(i));
         send(4'b1011, 8'h90 + 8'(i), 1'b0, 1'b0);
      end
      sts_clear(4'b0100);
      chk(par_sts == '0, "R9 cleared", int'(par_sts), 0);
      wait_drain("R9 data");

      // R4/R5 full port drops a cell
      drain_on = 1'b0;
      repeat (2) @(negedge clk);
      send_cell(3, 8'hA0, -1, 1'b1);
      chk(tx_clav == 4'hF, "R4 one cell stored", int'(tx_clav), 15);
      send_cell(3, 8'hB0, -1, 1'b1);
      chk(tx_clav == 4'b0111, "R4 full", int'(tx_clav), 7);
      send_cell(3, 8'hC0, -1, 1'b0);
      chk(tx_clav == 4'b0111, "R5 dropped cell", int'(tx_clav), 7);
      drain_on = 1'b1;
      wait_drain("R5 only two cells");
      chk(tx_clav == 4'hF, "R4 room after drain", int'(tx_clav), 15);

      // R4 pending bytes count; R6 restarts
      drain_on = 1'b0;
      repeat (2) @(negedge clk);
      send_cell(0, 8'h20, -1, 1'b1);
      send(4'b1110, 8'hE0, 1'b1, 1'b0);
      chk(tx_clav[0] == 1'b0, "R4 pending counted", int'(tx_clav[0]), 0);
      send_cell(0, 8'h28, -1, 1'b1);
      chk(tx_clav[0] == 1'b0, "R6 same-port restart", int'(tx_clav[0]), 0);
      send(4'b1101, 8'hD0, 1'b1, 1'b0);
      send(4'b1101, 8'hD1, 1'b0, 1'b0);
      send(4'b1101, 8'hD2, 1'b0, 1'b0);
      send_cell(2, 8'hF0, -1, 1'b1);
      chk(rd_avail == 4'b0101, "R6 partial discarded", int'(rd_avail), 5);
      drain_on = 1'b1;
      wait_drain("R6 restart delivery");
      chk(tx_clav == 4'hF, "R6 space freed", int'(tx_clav), 15);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule